// File: doc/BRIEF.md
# Cascaded Mappable Interrupt Controller

The block gathers level-sensitive interrupt requests into two primary groups of eight sources each. Each group drives one CPU interrupt line. A third set of eight "mappable" sources is shared between the two groups. Two separate mappable mask registers qualify that shared status. Each qualified result is ORed down to a single bit, and that bit takes the place of one reserved position in a primary group's status. This gives a two-level cascade: a mappable source reaches the CPU only when its mappable mask bit is set and the primary mask bit at the cascade position is also set.

For each group the block also presents a registered source code, so that the interrupt handler needs no scan. When the cascade bit is pending, the code names the highest pending mappable source. Otherwise it names the highest pending primary source. When nothing is pending, the code is zero and a valid flag stays low, which lets software detect a request that has already gone away.

All source inputs pass through a two-flop synchronizer. A small register port gives read access to the three status registers and read/write access to the four masks. No state machine is needed: the control path is a fixed pipeline of synchronizer, combinational qualification, and an output register.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: A group's line (`irq_g0` / `irq_g1`) is high exactly when that group's status ANDed with its primary mask is nonzero.
- R2: Group 0 status bit 3 equals the OR of (mappable status AND mappable mask 0). Group 1 status bit 3 equals the OR of (mappable status AND mappable mask 1). The same shared mappable status feeds both groups.
- R3: When a group's bit 3 is pending, its code is {1, group, index of the highest pending mappable bit}. This holds even when higher primary bits are also pending.
- R4: Otherwise the code is {0, group, index of the highest pending primary bit}. Bit 7 has the highest priority and bit 0 the lowest. Code bit 4 selects mappable, bit 3 is the group number, and bits 2:0 are the index.
- R5: With nothing pending, the valid flag is 0 and the code is 5'h00.
- R6: After reset, all four mask registers read 0 and both lines are low.
- R7: Register offsets are: 0 group 0 status, 1 group 0 mask, 2 group 1 status, 3 group 1 mask, 4 mappable status, 5 mappable mask 0, 6 mappable mask 1. A write to 1, 3, 5 or 6 is read back unchanged.
- R8: Writes to offsets 0, 2, 4 and 7 change no register. Reading offset 7 returns 0.
- R9: The external primary input at bit 3 of each group is ignored.
- R10: A status bit clears when its source deasserts, and the line then falls.
- R11: The line and code change one clock after the clock edge that writes a mask.
- R12: A change on a source input reaches the line on the third rising edge: two synchronizer stages, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_g0 | input | 8 | Group 0 level requests (bit 3 unused) |
| src_g1 | input | 8 | Group 1 level requests (bit 3 unused) |
| src_map | input | 8 | Shared mappable level requests |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data at `addr` |
| irq_g0 | output | 1 | Group 0 CPU interrupt line |
| irq_g1 | output | 1 | Group 1 CPU interrupt line |
| valid_g0 | output | 1 | Group 0 code valid |
| code_g0 | output | 5 | Group 0 source code |
| valid_g1 | output | 1 | Group 1 code valid |
| code_g1 | output | 5 | Group 1 source code |

## Verification
A corrupted mask register shows on the read port at once. It shows on the line and code one clock after the bad value is latched. A wrong synchronizer stage shifts the moment the line rises away from the third edge, so the directed latency test checks the edge cycle by cycle. A wrong cascade selection or priority order shows as a wrong code on the next output register update. For this reason each pattern is sampled after the pipeline has settled, using codes chosen so that a primary bit and a mappable bit compete.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_STAT0  = 3'd0,
        OFS_MASK0  = 3'd1,
        OFS_STAT1  = 3'd2,
        OFS_MASK1  = 3'd3,
        OFS_MSTAT  = 3'd4,
        OFS_MMASK0 = 3'd5,
        OFS_MMASK1 = 3'd6,
        OFS_NONE   = 3'd7
    } reg_ofs_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
    import irq_cascade_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wr_data,
    output logic [1:0][W-1:0] grp_mask,
    output logic [1:0][W-1:0] map_mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_mask <= '0;
            map_mask <= '0;
        end else if (wr_en) begin
            case (reg_ofs_e'(addr))
                OFS_MASK0:  grp_mask[0] <= wr_data;
                OFS_MASK1:  grp_mask[1] <= wr_data;
                OFS_MMASK0: map_mask[0] <= wr_data;
                OFS_MMASK1: map_mask[1] <= wr_data;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/irq_group.sv
module irq_group #(
    parameter int W        = 8,
    parameter int IW       = $clog2(W),
    parameter int CASC_BIT = 3,
    parameter bit GRP_ID   = 1'b0,
    localparam int CW      = IW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  raw_stat,
    input  logic [W-1:0]  casc_vec,
    input  logic [W-1:0]  mask,
    output logic [W-1:0]  stat,
    output logic          irq,
    output logic          valid,
    output logic [CW-1:0] code
);
    logic [W-1:0]  pend;
    logic          p_any, m_any;
    logic [IW-1:0] p_idx, m_idx;
    logic [CW-1:0] code_d;

    always_comb begin
        stat           = raw_stat;
        stat[CASC_BIT] = |casc_vec;
    end

    assign pend = stat & mask;

    irq_prio_enc #(.W(W), .IW(IW)) u_prim (.vec(pend),     .any(p_any), .idx(p_idx));
    irq_prio_enc #(.W(W), .IW(IW)) u_map  (.vec(casc_vec), .any(m_any), .idx(m_idx));

    always_comb begin
        if (pend[CASC_BIT])
            code_d = {1'b1, GRP_ID, m_idx};
        else if (p_any)
            code_d = {1'b0, GRP_ID, p_idx};
        else
            code_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq   <= 1'b0;
            valid <= 1'b0;
            code  <= '0;
        end else begin
            irq   <= p_any;
            valid <= p_any;
            code  <= code_d;
        end
    end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irq_cascade_pkg::*;
#(
    parameter int W        = 8,
    parameter int CASC_BIT = 3,
    localparam int IW      = $clog2(W),
    localparam int CW      = IW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      src_g0,
    input  logic [W-1:0]      src_g1,
    input  logic [W-1:0]      src_map,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      rd_data,
    output logic              irq_g0,
    output logic              irq_g1,
    output logic              valid_g0,
    output logic [CW-1:0]     code_g0,
    output logic              valid_g1,
    output logic [CW-1:0]     code_g1
);
    logic [3*W-1:0]    sync_q;
    logic [W-1:0]      map_stat;
    logic [1:0][W-1:0] raw_arr;
    logic [1:0][W-1:0] stat_arr;
    logic [1:0][W-1:0] mask_arr;
    logic [1:0][W-1:0] mmask_arr;
    logic [1:0]        irq_arr, valid_arr;
    logic [1:0][CW-1:0] code_arr;

    irq_sync #(.W(3*W)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({src_map, src_g1, src_g0}),
        .q(sync_q)
    );

    assign raw_arr[0] = sync_q[W-1:0];
    assign raw_arr[1] = sync_q[2*W-1:W];
    assign map_stat   = sync_q[3*W-1:2*W];

    irq_mask_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .grp_mask(mask_arr), .map_mask(mmask_arr)
    );

    for (genvar g = 0; g < 2; g++) begin : g_grp
        irq_group #(.W(W), .IW(IW), .CASC_BIT(CASC_BIT), .GRP_ID(g[0])) u_grp (
            .clk(clk), .rst_n(rst_n),
            .raw_stat(raw_arr[g]),
            .casc_vec(map_stat & mmask_arr[g]),
            .mask(mask_arr[g]),
            .stat(stat_arr[g]),
            .irq(irq_arr[g]),
            .valid(valid_arr[g]),
            .code(code_arr[g])
        );
    end

    assign irq_g0   = irq_arr[0];
    assign irq_g1   = irq_arr[1];
    assign valid_g0 = valid_arr[0];
    assign valid_g1 = valid_arr[1];
    assign code_g0  = code_arr[0];
    assign code_g1  = code_arr[1];

    always_comb begin
        case (reg_ofs_e'(addr))
            OFS_STAT0:  rd_data = stat_arr[0];
            OFS_MASK0:  rd_data = mask_arr[0];
            OFS_STAT1:  rd_data = stat_arr[1];
            OFS_MASK1:  rd_data = mask_arr[1];
            OFS_MSTAT:  rd_data = map_stat;
            OFS_MMASK0: rd_data = mmask_arr[0];
            OFS_MMASK1: rd_data = mmask_arr[1];
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk #(
    parameter int W        = 8,
    parameter int CASC_BIT = 3,
    parameter int CW       = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        addr,
    input logic [W-1:0]      wr_data,
    input logic              irq_g0,
    input logic              irq_g1,
    input logic              valid_g0,
    input logic              valid_g1,
    input logic [CW-1:0]     code_g0,
    input logic [CW-1:0]     code_g1,
    input logic [1:0][W-1:0] stat_arr,
    input logic [1:0][W-1:0] mask_arr,
    input logic [1:0][W-1:0] mmask_arr
);
    // R1: line follows pending set of the previous cycle
    p_line_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_g0 == $past(|(stat_arr[0] & mask_arr[0])));
    p_line_pending_g1_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_g1 == $past(|(stat_arr[1] & mask_arr[1])));

    // R3: a mappable code implies the cascade bit was pending
    p_casc_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_g0 && code_g0[CW-1]) |-> $past(stat_arr[0][CASC_BIT] & mask_arr[0][CASC_BIT]));

    // R5: no request means a zero code
    p_none_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_g0 |-> (code_g0 == '0));
    p_none_zero_g1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_g1 |-> (code_g1 == '0));

    // R7: a mask write is stored
    p_mask_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd1) |=> (mask_arr[0] == $past(wr_data)));

    // R8: masks change only on a write to a mask offset
    p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == 3'd1 || addr == 3'd3 || addr == 3'd5 || addr == 3'd6))
        |=> ($stable(mask_arr) && $stable(mmask_arr)));

    // R6: quiet while in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r6: assert (!irq_g0 && !irq_g1 && mask_arr == '0 && mmask_arr == '0);
        end
    end
endmodule

bind irq_cascade_ctrl irq_cascade_chk #(.W(W), .CASC_BIT(CASC_BIT), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .irq_g0(irq_g0), .irq_g1(irq_g1), .valid_g0(valid_g0), .valid_g1(valid_g1),
    .code_g0(code_g0), .code_g1(code_g1),
    .stat_arr(stat_arr), .mask_arr(mask_arr), .mmask_arr(mmask_arr)
);

// File: tb/sim_irq_cascade_ctrl.sv
module sim_irq_cascade_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_g0 = '0, src_g1 = '0, src_map = '0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_g0, irq_g1, valid_g0, valid_g1;
    logic [4:0] code_g0, code_g1;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    irq_cascade_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_g0(src_g0), .src_g1(src_g1), .src_map(src_map),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .irq_g0(irq_g0), .irq_g1(irq_g1), .valid_g0(valid_g0), .code_g0(code_g0),
        .valid_g1(valid_g1), .code_g1(code_g1)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk);
        src_g0 = '0; src_g1 = '0; src_map = '0;
        wr(3'd1, 8'h00); wr(3'd3, 8'h00); wr(3'd5, 8'h00); wr(3'd6, 8'h00);
        settle();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R6 irq_g0", {7'b0, irq_g0}, 8'h00);
        check("R6 irq_g1", {7'b0, irq_g1}, 8'h00);
        check("R5 code_g0 idle", {2'b0, valid_g0, code_g0}, 8'h00);
        rd(3'd1, d); check("R6 mask0", d, 8'h00);
        rd(3'd3, d); check("R6 mask1", d, 8'h00);
        rd(3'd5, d); check("R6 mmask0", d, 8'h00);
        rd(3'd6, d); check("R6 mmask1", d, 8'h00);
    endtask

    task automatic t_primary();
        @(negedge clk); src_g0 = 8'h81;
        settle();
        check("R1 masked off", {7'b0, irq_g0}, 8'h00);
        wr(3'd1, 8'h81); settle();
        check("R1 line up", {7'b0, irq_g0}, 8'h01);
        check("R4 top bit wins", {2'b0, valid_g0, code_g0}, 8'h27);
        wr(3'd1, 8'h01); settle();
        check("R4 bit0 code", {2'b0, valid_g0, code_g0}, 8'h20);
        @(negedge clk); src_g1 = 8'h24;
        wr(3'd3, 8'hFF); settle();
        check("R4 group1 code", {2'b0, valid_g1, code_g1}, 8'h2D);
        clear_all();
    endtask

    task automatic t_cascade();
        logic [7:0] d;
        @(negedge clk); src_map = 8'h12; src_g0 = 8'h80;
        wr(3'd5, 8'h02); wr(3'd1, 8'h88);
        wr(3'd6, 8'h10); wr(3'd3, 8'h08);
        settle();
        check("R3 g0 cascade over bit7", {2'b0, valid_g0, code_g0}, 8'h31);
        check("R3 g1 cascade", {2'b0, valid_g1, code_g1}, 8'h3C);
        rd(3'd0, d); check("R2 stat0", d, 8'h88);
        rd(3'd2, d); check("R2 stat1", d, 8'h08);
        rd(3'd4, d); check("R7 map stat", d, 8'h12);
        wr(3'd5, 8'h00); settle();
        check("R2 g0 cascade gone", {2'b0, valid_g0, code_g0}, 8'h27);
        clear_all();
    endtask

    task automatic t_ignored();
        logic [7:0] d;
        @(negedge clk); src_g0 = 8'h08;
        wr(3'd1, 8'h08); settle();
        check("R9 ext bit3 ignored", {7'b0, irq_g0}, 8'h00);
        rd(3'd0, d); check("R9 stat0 bit3", d, 8'h00);
        wr(3'd1, 8'h5A);
        wr(3'd0, 8'hFF); wr(3'd2, 8'hFF); wr(3'd4, 8'hFF); wr(3'd7, 8'hFF);
        rd(3'd1, d); check("R8 mask0 kept", d, 8'h5A);
        rd(3'd3, d); check("R8 mask1 kept", d, 8'h00);
        rd(3'd5, d); check("R8 mmask0 kept", d, 8'h00);
        rd(3'd6, d); check("R8 mmask1 kept", d, 8'h00);
        rd(3'd7, d); check("R8 offset7 zero", d, 8'h00);
        wr(3'd6, 8'hC3); rd(3'd6, d); check("R7 mmask1 rw", d, 8'hC3);
        clear_all();
    endtask

    task automatic t_level();
        @(negedge clk); src_g1 = 8'h40;
        wr(3'd3, 8'h40); settle();
        check("R10 up", {7'b0, irq_g1}, 8'h01);
        @(negedge clk); src_g1 = 8'h00;
        settle();
        check("R10 cleared", {7'b0, irq_g1}, 8'h00);
        check("R5 none", {2'b0, valid_g1, code_g1}, 8'h00);
        clear_all();
    endtask

    task automatic t_timing();
        @(negedge clk); src_g0 = 8'h02;
        settle();
        @(negedge clk); wr_en = 1'b1; addr = 3'd1; wr_data = 8'h02;
        @(negedge clk); wr_en = 1'b0;
        check("R11 not yet", {7'b0, irq_g0}, 8'h00);
        @(negedge clk);
        check("R11 one clock", {7'b0, irq_g0}, 8'h01);
        @(negedge clk); src_g0 = 8'h00;
        settle();
        @(negedge clk); src_g0 = 8'h02;
        @(negedge clk); @(negedge clk);
        check("R12 after two edges", {7'b0, irq_g0}, 8'h00);
        @(negedge clk);
        check("R12 third edge", {7'b0, irq_g0}, 8'h01);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_primary();
        t_cascade();
        t_ignored();
        t_level();
        t_timing();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule